// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the target-side serial engine of a byte-addressed memory reached over a four-wire SPI link. The bus pins (chip select, serial clock, serial data in, hold) are sampled by a fast system clock. The block turns each select frame into an 8-bit instruction, an optional 16-bit address and a stream of data bytes. Read data is fetched from a synchronous RAM port one byte ahead of need. Status bytes come from a parallel status input. Write-side traffic leaves as single-cycle strobes for the storage and protection logic that sits behind the block.

The link runs in clock-idle-low or clock-idle-high mode with no configuration. Incoming bits are taken on the rising serial-clock edge, and outgoing bits are updated on the falling edge. A hold input pauses a frame at any bit: the output is released and the position is kept. Opcodes outside the supported set make the block ignore the rest of the frame.

Top module: `sfe_front`

## Requirements
- R1: The output enable `sdo_oe` is low after reset and whenever chip select has been high for more than the synchronizer depth; no strobe fires after reset until a frame is sent.
- R2: Both idle-low (mode 0) and idle-high (mode 3) serial clocks work: input bits are taken on SCK rising edges, and output bits change on SCK falling edges.
- R3: Opcode 0x06 gives one `wr_en_cmd` pulse and opcode 0x04 gives one `wr_dis_cmd` pulse, each once per frame.
- R4: Opcode 0x05 drives `status_in` out MSB first, starting at the first falling edge after the opcode, and repeats it for every further byte clocked.
- R5: Opcode 0x03 is followed by 16 address bits, MSB first; the top 3 bits are ignored. The byte stored at the low 13 bits is then driven MSB first.
- R6: A read continues as long as SCK runs, the address rising by one per byte; after 0x1FFF it wraps to 0x0000.
- R7: Opcode 0x02 plus 16 address bits: each following complete data byte gives one `mem_wr` strobe carrying the byte and its address, the address rising by one per byte and wrapping at 0x1FFF.
- R8: Opcode 0x01: the next complete byte gives one `stat_wr` strobe with that byte on `stat_wdata`; later bits of the frame are ignored.
- R9: Any other opcode value is ignored: no strobe fires and `sdo_oe` stays low for the rest of the frame.
- R10: `hold_n` is taken into account only while SCK is low. While held inside a frame, `sdo_oe` is low, `sdo` is frozen, and SCK and SI activity is ignored. Release with SCK low resumes at the same bit.
- R11: Chip select rising mid-frame discards partial bits and decode state; the next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for `sdo` (low means high impedance) |
| mem_rd | output | 1 | RAM read request, data expected the next cycle |
| mem_addr | output | AW | RAM read address |
| mem_rdata | input | 8 | RAM read data |
| status_in | input | 8 | Status byte returned by the status-read opcode |
| wr_en_cmd | output | 1 | One-cycle pulse: write-enable opcode received |
| wr_dis_cmd | output | 1 | One-cycle pulse: write-disable opcode received |
| stat_wr | output | 1 | One-cycle strobe: status write byte received |
| stat_wdata | output | 8 | Byte for the status write |
| mem_wr | output | 1 | One-cycle strobe: memory write byte received |
| mem_waddr | output | AW | Address of the memory write byte |
| mem_wdata | output | 8 | Memory write byte |

## Verification
A bit counter or phase that slips by one shows at the ports within the same frame. Read bytes come out rotated, a status byte is misaligned, or a write strobe carries a shifted byte and address by the end of the first data byte. A stale read pointer shows as a wrong second byte or a missing wrap at the top address. Faulty hold gating shows as `sdo_oe` high during the pause, or as a corrupted bit right after release. Leftover state from an aborted frame shows as a wrong decode on the very next opcode.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [BYTE_W-1:0] {
      OP_WRSR  = 8'h01,
      OP_WRITE = 8'h02,
      OP_READ  = 8'h03,
      OP_WRDI  = 8'h04,
      OP_RDSR  = 8'h05,
      OP_WREN  = 8'h06
   } opcode_e;

   typedef enum logic [2:0] {
      PH_OPC,    // collecting instruction
      PH_ADDR,   // collecting address bytes
      PH_RDATA,  // streaming array data out
      PH_WDATA,  // collecting array write bytes
      PH_STAT,   // streaming status out
      PH_SRDATA, // collecting status write byte
      PH_SINK    // frame finished or rejected
   } phase_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{INIT}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
   import sfe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CW = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sh_q;
   logic [CW-1:0]     cnt_q;

   assign byte_val  = {sh_q[BYTE_W-2:0], bit_in};
   assign byte_done = shift_en && (cnt_q == CW'(BYTE_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= byte_val;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
   import sfe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              shift_en,
   output logic              bit_out,
   output logic              started,
   output logic              wrap
);
   localparam int CW = $clog2(BYTE_W);

   logic [BYTE_W-1:0] buf_q;
   logic [CW-1:0]     cnt_q;

   assign wrap = shift_en && (cnt_q == CW'(BYTE_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         cnt_q   <= '0;
         bit_out <= 1'b0;
         started <= 1'b0;
      end else if (clr) begin
         cnt_q   <= '0;
         bit_out <= 1'b0;
         started <= 1'b0;
      end else begin
         if (load) buf_q <= load_val;
         if (shift_en) begin
            bit_out <= buf_q[CW'(BYTE_W-1) - cnt_q];
            cnt_q   <= cnt_q + 1'b1;
            started <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sfe_front.sv
module sfe_front
   import sfe_pkg::*;
#(
   parameter int AW = 13,
   parameter int FRAME_AW = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic              hold_n,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              mem_rd,
   output logic [AW-1:0]     mem_addr,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic [BYTE_W-1:0] status_in,
   output logic              wr_en_cmd,
   output logic              wr_dis_cmd,
   output logic              stat_wr,
   output logic [BYTE_W-1:0] stat_wdata,
   output logic              mem_wr,
   output logic [AW-1:0]     mem_waddr,
   output logic [BYTE_W-1:0] mem_wdata
);
   localparam int ADDR_BYTES = FRAME_AW / BYTE_W;
   localparam int ABC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   generate
      if (FRAME_AW % BYTE_W != 0 || FRAME_AW < BYTE_W) begin : g_bad_frame
         $error("sfe_front: FRAME_AW must be a whole number of bytes");
      end
      if (AW > FRAME_AW || AW < 1) begin : g_bad_aw
         $error("sfe_front: AW must fit inside FRAME_AW");
      end
   endgenerate

   // ---------------- pin synchronization ----------------
   logic s_cs_n, s_sck, s_sdi, s_hold_n;
   sfe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .INIT(4'b1001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, sdi, hold_n}),
      .q     ({s_cs_n, s_sck, s_sdi, s_hold_n})
   );

   logic sck_q, hold_act;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         hold_act <= 1'b0;
      end else begin
         sck_q <= s_sck;
         if (s_cs_n)      hold_act <= 1'b0;
         else if (!s_sck) hold_act <= ~s_hold_n;
      end
   end

   logic live, rx_en, fall_en;
   assign live    = ~s_cs_n & ~hold_act;
   assign rx_en   = live & s_sck & ~sck_q;
   assign fall_en = live & ~s_sck & sck_q;

   // ---------------- deserializer ----------------
   logic              rx_done;
   logic [BYTE_W-1:0] rx_byte;
   sfe_rx u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (s_cs_n),
      .shift_en  (rx_en),
      .bit_in    (s_sdi),
      .byte_done (rx_done),
      .byte_val  (rx_byte)
   );

   // ---------------- decode state ----------------
   phase_e              phase_q;
   logic                is_read_q;
   logic [ABC_W-1:0]    abyte_q;
   logic [FRAME_AW-1:0] acc_q, acc_next;
   logic [AW-1:0]       ptr_q;
   logic                ld_q;

   logic op_done, addr_last, tx_on, tx_wrap, rd_now, st_load, tx_load;
   logic [BYTE_W-1:0] tx_val;
   logic tx_started;

   assign op_done   = rx_done && (phase_q == PH_OPC);
   assign addr_last = rx_done && (phase_q == PH_ADDR) && (abyte_q == ABC_W'(ADDR_BYTES-1));
   assign acc_next  = FRAME_AW'({acc_q, rx_byte});
   assign tx_on     = (phase_q == PH_RDATA) || (phase_q == PH_STAT);

   assign rd_now   = (addr_last && is_read_q) || ((phase_q == PH_RDATA) && tx_wrap);
   assign mem_rd   = rd_now;
   assign mem_addr = addr_last ? acc_next[AW-1:0] : ptr_q;

   assign st_load = (op_done && rx_byte == OP_RDSR) || ((phase_q == PH_STAT) && tx_wrap);
   assign tx_load = ld_q | st_load;
   assign tx_val  = ld_q ? mem_rdata : status_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_OPC;
         is_read_q <= 1'b0;
         abyte_q   <= '0;
         acc_q     <= '0;
         ptr_q     <= '0;
         ld_q      <= 1'b0;
      end else begin
         ld_q <= rd_now;
         if (rd_now) ptr_q <= mem_addr + 1'b1;
         if (s_cs_n) begin
            phase_q <= PH_OPC;
            abyte_q <= '0;
            acc_q   <= '0;
         end else if (rx_done) begin
            unique case (phase_q)
               PH_OPC: begin
                  unique case (rx_byte)
                     OP_READ:  begin phase_q <= PH_ADDR; is_read_q <= 1'b1; end
                     OP_WRITE: begin phase_q <= PH_ADDR; is_read_q <= 1'b0; end
                     OP_RDSR:  phase_q <= PH_STAT;
                     OP_WRSR:  phase_q <= PH_SRDATA;
                     default:  phase_q <= PH_SINK;
                  endcase
               end
               PH_ADDR: begin
                  acc_q   <= acc_next;
                  abyte_q <= abyte_q + 1'b1;
                  if (addr_last) begin
                     phase_q <= is_read_q ? PH_RDATA : PH_WDATA;
                     if (!is_read_q) ptr_q <= acc_next[AW-1:0];
                  end
               end
               PH_WDATA:  ptr_q   <= ptr_q + 1'b1;
               PH_SRDATA: phase_q <= PH_SINK;
               default: ;
            endcase
         end
      end
   end

   // ---------------- strobes toward the back end ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_cmd  <= 1'b0;
         wr_dis_cmd <= 1'b0;
         stat_wr    <= 1'b0;
         stat_wdata <= '0;
         mem_wr     <= 1'b0;
         mem_waddr  <= '0;
         mem_wdata  <= '0;
      end else begin
         wr_en_cmd  <= op_done && (rx_byte == OP_WREN);
         wr_dis_cmd <= op_done && (rx_byte == OP_WRDI);
         stat_wr    <= rx_done && (phase_q == PH_SRDATA);
         mem_wr     <= rx_done && (phase_q == PH_WDATA);
         if (rx_done) begin
            stat_wdata <= rx_byte;
            mem_wdata  <= rx_byte;
            mem_waddr  <= ptr_q;
         end
      end
   end

   // ---------------- serializer ----------------
   sfe_tx u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (s_cs_n),
      .load     (tx_load),
      .load_val (tx_val),
      .shift_en (fall_en & tx_on),
      .bit_out  (sdo),
      .started  (tx_started),
      .wrap     (tx_wrap)
   );

   assign sdo_oe = live & tx_on & tx_started;
endmodule

// File: rtl/sfe_front_chk.sv
module sfe_front_chk #(
   parameter int AW = 13,
   parameter int SYNC_STAGES = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          sdo,
   input logic          sdo_oe,
   input logic          hold_act,
   input logic          mem_rd,
   input logic [AW-1:0] mem_addr,
   input logic          mem_wr,
   input logic [AW-1:0] mem_waddr,
   input logic          wr_en_cmd,
   input logic          wr_dis_cmd,
   input logic          stat_wr
);
   localparam int HW = $clog2(SYNC_STAGES + 2) + 1;

   logic [HW-1:0] hi_cnt;
   logic [AW-1:0] last_rd, last_wr;
   logic          have_rd, have_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt  <= '0;
         last_rd <= '0;
         last_wr <= '0;
         have_rd <= 1'b0;
         have_wr <= 1'b0;
      end else begin
         if (!cs_n) hi_cnt <= '0;
         else if (hi_cnt <= HW'(SYNC_STAGES)) hi_cnt <= hi_cnt + 1'b1;
         if (mem_rd) begin last_rd <= mem_addr; have_rd <= 1'b1; end
         else if (cs_n) have_rd <= 1'b0;
         if (mem_wr) begin last_wr <= mem_waddr; have_wr <= 1'b1; end
         else if (cs_n) have_wr <= 1'b0;
      end
   end

   // R1: deselected long enough means the output is released
   a_r1_released_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > HW'(SYNC_STAGES)) |-> !sdo_oe);

   // R10: held output keeps its value
   a_r10_hold_freezes_sdo: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && $past(hold_act)) |-> $stable(sdo));

   // R6: consecutive reads of one frame step by one, wrapping at the top
   a_r6_read_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && have_rd) |-> (mem_addr == AW'(last_rd + 1'b1)));

   // R7: consecutive write strobes of one frame step by one
   a_r7_write_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && have_wr) |-> (mem_waddr == AW'(last_wr + 1'b1)));

   // R3: command strobes never overlap
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en_cmd, wr_dis_cmd, stat_wr, mem_wr}));
endmodule

bind sfe_front sfe_front_chk #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sdo        (sdo),
   .sdo_oe     (sdo_oe),
   .hold_act   (hold_act),
   .mem_rd     (mem_rd),
   .mem_addr   (mem_addr),
   .mem_wr     (mem_wr),
   .mem_waddr  (mem_waddr),
   .wr_en_cmd  (wr_en_cmd),
   .wr_dis_cmd (wr_dis_cmd),
   .stat_wr    (stat_wr)
);

// File: tb/sfe_front_bench.sv
module sfe_front_bench;
   localparam int AW = 13;
   localparam int H  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
   logic sdo, sdo_oe, mem_rd, wr_en_cmd, wr_dis_cmd, stat_wr, mem_wr;
   logic [AW-1:0] mem_addr, mem_waddr;
   logic [7:0] mem_rdata = 8'h00, status_in = 8'h00, stat_wdata, mem_wdata;

   int checks = 0, errors = 0;
   bit mode3 = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sfe_front u_sfe_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
      .sdo(sdo), .sdo_oe(sdo_oe), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .status_in(status_in), .wr_en_cmd(wr_en_cmd),
      .wr_dis_cmd(wr_dis_cmd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   function automatic logic [7:0] pat(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
   endfunction

   // storage model: synchronous read port
   always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

   // strobe monitors
   int en_cnt = 0, dis_cnt = 0, sw_cnt = 0, wcnt = 0;
   logic [7:0] sw_last = 8'h00;
   logic [12:0] wlog_a [256];
   logic [7:0]  wlog_d [256];
   always @(posedge clk) begin
      if (wr_en_cmd)  en_cnt  <= en_cnt + 1;
      if (wr_dis_cmd) dis_cnt <= dis_cnt + 1;
      if (stat_wr) begin sw_cnt <= sw_cnt + 1; sw_last <= stat_wdata; end
      if (mem_wr && wcnt < 256) begin
         wlog_a[wcnt] <= mem_waddr;
         wlog_d[wcnt] <= mem_wdata;
         wcnt <= wcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_start();
      sck = mode3;
      wclk(H);
      cs_n = 1'b0;
      wclk(H);
   endtask

   task automatic cs_end();
      sck = mode3;
      wclk(H);
      cs_n = 1'b1;
      wclk(2 * H);
   endtask

   // one byte; hold_bit >= 0 inserts a pause with SCK low before that bit is sampled
   task automatic xbyte(input logic [7:0] o, input int hold_bit,
                        output logic [7:0] i, output bit oe_all, output bit oe_hold);
      oe_all = 1'b1;
      oe_hold = 1'b0;
      for (int b = 7; b >= 0; b--) begin
         sck = 1'b0;
         sdi = o[b];
         wclk(H);
         if (b == hold_bit) begin
            hold_n = 1'b0;
            wclk(H);
            oe_hold |= sdo_oe;
            for (int t = 0; t < 2; t++) begin
               sdi = ~o[b]; sck = 1'b1; wclk(H);
               oe_hold |= sdo_oe;
               sdi = o[b];  sck = 1'b0; wclk(H);
            end
            hold_n = 1'b1;
            wclk(H);
         end
         i[b] = sdo;
         oe_all &= sdo_oe;
         sck = 1'b1;
         wclk(H);
      end
   endtask

   task automatic do_read(input bit m3, input logic [15:0] a, input int n,
                          input int hbyte, input int hbit, input string tag);
      logic [7:0] r, e;
      bit oa, oh;
      logic [12:0] ea;
      mode3 = m3;
      cs_start();
      xbyte(8'h03, -1, r, oa, oh);
      chk(oa == 1'b0, {tag, " R5 no drive during opcode"}, oa, 0);
      xbyte(a[15:8], -1, r, oa, oh);
      xbyte(a[7:0], -1, r, oa, oh);
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, (k == hbyte) ? hbit : -1, r, oa, oh);
         ea = a[12:0] + 13'(k);
         e = pat(ea);
         chk(r == e, {tag, " R5 R6 read byte"}, r, e);
         chk(oa == 1'b1, {tag, " R2 R5 output driven"}, oa, 1);
         if (k == hbyte) chk(oh == 1'b0, {tag, " R10 released while held"}, oh, 0);
      end
      cs_end();
      chk(sdo_oe == 1'b0, {tag, " R1 released after frame"}, sdo_oe, 0);
   endtask

   task automatic do_write(input bit m3, input logic [15:0] a, input int n,
                           input int hbyte, input int hbit, input string tag);
      logic [7:0] r, d [8];
      bit oa, oh;
      int base;
      logic [12:0] ea;
      mode3 = m3;
      base = wcnt;
      cs_start();
      xbyte(8'h02, -1, r, oa, oh);
      xbyte(a[15:8], -1, r, oa, oh);
      xbyte(a[7:0], -1, r, oa, oh);
      for (int k = 0; k < n; k++) begin
         d[k] = 8'($urandom);
         xbyte(d[k], (k == hbyte) ? hbit : -1, r, oa, oh);
      end
      cs_end();
      chk(wcnt == base + n, {tag, " R7 write strobe count"}, wcnt, base + n);
      for (int k = 0; k < n && base + k < 256; k++) begin
         ea = a[12:0] + 13'(k);
         chk(wlog_a[base + k] == ea, {tag, " R7 write address"}, wlog_a[base + k], ea);
         chk(wlog_d[base + k] == d[k], {tag, " R7 R10 write data"}, wlog_d[base + k], d[k]);
      end
   endtask

   task automatic do_rdsr(input bit m3, input logic [7:0] st, input int n, input string tag);
      logic [7:0] r;
      bit oa, oh;
      mode3 = m3;
      status_in = st;
      cs_start();
      xbyte(8'h05, -1, r, oa, oh);
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, -1, r, oa, oh);
         chk(r == st, {tag, " R4 status byte"}, r, st);
      end
      cs_end();
   endtask

   task automatic do_wrsr(input bit m3, input logic [7:0] d, input string tag);
      logic [7:0] r;
      bit oa, oh;
      int base;
      mode3 = m3;
      base = sw_cnt;
      cs_start();
      xbyte(8'h01, -1, r, oa, oh);
      xbyte(d, -1, r, oa, oh);
      xbyte(8'h5A, -1, r, oa, oh);
      cs_end();
      chk(sw_cnt == base + 1, {tag, " R8 status write count"}, sw_cnt, base + 1);
      chk(sw_last == d, {tag, " R8 status write data"}, sw_last, d);
   endtask

   // single opcode frame followed by two filler bytes
   task automatic do_op(input bit m3, input logic [7:0] op, output bit oe_any);
      logic [7:0] r;
      bit oa, oh;
      mode3 = m3;
      oe_any = 1'b0;
      cs_start();
      for (int k = 0; k < 3; k++) begin
         xbyte((k == 0) ? op : 8'hA5, -1, r, oa, oh);
         oe_any |= oa;
      end
      cs_end();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stimulus
      bit oe_any;
      int e0, d0, s0, w0;
      logic [7:0] r;
      bit oa, oh;
      void'($urandom(32'h5EED_1234));
      wclk(5);
      rst_n = 1'b1;
      wclk(10);

      // R1 reset state
      chk(sdo_oe == 1'b0, "R1 reset output enable", sdo_oe, 0);
      chk(en_cnt + dis_cnt + sw_cnt + wcnt == 0, "R1 no strobes after reset",
          en_cnt + dis_cnt + sw_cnt + wcnt, 0);

      // R4 status, both modes
      do_rdsr(1'b0, 8'hA5, 2, "m0");
      do_rdsr(1'b1, 8'h3C, 2, "m3");

      // R5 read, upper address bits ignored; R2 mode 3
      do_read(1'b0, 16'hE123, 3, -1, -1, "m0 upper bits");
      do_read(1'b1, 16'h0040, 3, -1, -1, "m3");

      // R6 wrap at the top address
      do_read(1'b0, 16'h1FFE, 4, -1, -1, "m0 R6 wrap");
      do_read(1'b1, 16'hFFFF, 2, -1, -1, "m3 R6 wrap");

      // R7 write with address wrap
      do_write(1'b0, 16'h0100, 3, -1, -1, "m0");
      do_write(1'b1, 16'h3FFF, 2, -1, -1, "m3 wrap");

      // R8 status write
      do_wrsr(1'b0, 8'h8C, "m0");
      do_wrsr(1'b1, 8'h04, "m3");

      // R3 enable / disable commands
      e0 = en_cnt; d0 = dis_cnt;
      do_op(1'b0, 8'h06, oe_any);
      chk(en_cnt == e0 + 1, "R3 write-enable pulse", en_cnt, e0 + 1);
      do_op(1'b1, 8'h04, oe_any);
      chk(dis_cnt == d0 + 1, "R3 write-disable pulse", dis_cnt, d0 + 1);
      chk(en_cnt == e0 + 1, "R3 enable count unchanged by disable", en_cnt, e0 + 1);

      // R9 unknown opcodes
      foreach (r[i]) begin end
      for (int t = 0; t < 3; t++) begin
         logic [7:0] bad;
         bad = (t == 0) ? 8'hFF : (t == 1) ? 8'h00 : 8'h07;
         e0 = en_cnt; d0 = dis_cnt; s0 = sw_cnt; w0 = wcnt;
         do_op(t[0], bad, oe_any);
         chk(oe_any == 1'b0, "R9 no drive after unknown opcode", oe_any, 0);
         chk((en_cnt - e0) + (dis_cnt - d0) + (sw_cnt - s0) + (wcnt - w0) == 0,
             "R9 no strobe after unknown opcode",
             (en_cnt - e0) + (dis_cnt - d0) + (sw_cnt - s0) + (wcnt - w0), 0);
      end

      // R10 hold in a read and in a write
      do_read(1'b0, 16'h0777, 2, 0, 4, "m0 hold");
      do_read(1'b1, 16'h1A00, 2, 1, 0, "m3 hold");
      do_write(1'b0, 16'h0200, 2, 0, 3, "m0 hold");

      // R11 aborted frames, then a fresh decode
      mode3 = 1'b0;
      cs_start();
      for (int b = 7; b >= 4; b--) begin
         sck = 1'b0; sdi = b[0]; wclk(H); sck = 1'b1; wclk(H);
      end
      cs_end();
      do_rdsr(1'b0, 8'h96, 1, "R11 after partial opcode");
      w0 = wcnt;
      mode3 = 1'b1;
      cs_start();
      xbyte(8'h02, -1, r, oa, oh);
      xbyte(8'h00, -1, r, oa, oh);
      cs_end();
      chk(wcnt == w0, "R11 aborted write gives no strobe", wcnt, w0);
      do_read(1'b1, 16'h0033, 2, -1, -1, "R11 after aborted address");

      // randomized frames
      for (int it = 0; it < 14; it++) begin
         bit m;
         int kind, n;
         logic [15:0] a;
         m = 1'($urandom);
         kind = int'($urandom_range(0, 2));
         n = int'($urandom_range(1, 4));
         a = 16'($urandom);
         if (it < 3) a = {3'($urandom), 13'h1FFF - 13'(it)};
         case (kind)
            0: do_read(m, a, n, -1, -1, "rand");
            1: do_write(m, a, n, -1, -1, "rand");
            default: do_rdsr(m, 8'($urandom), n, "rand");
         endcase
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule